// File: doc/BRIEF.md
# Interrupt and Halt Controller

This block decides when a Z80-style core takes an interrupt and where the core goes next. It holds the two interrupt-enable flip-flops (a master enable and its shadow), the interrupt mode (0, 1 or 2), a 16-bit vector base register and the halted state. The core reports each instruction boundary and pulses strobes for enable, disable, return-from-NMI, mode select, vector-base load and halt entry. These strobes arrive in the same cycle as the boundary that ends the instruction.

On acceptance the block issues a one-cycle dispatch pulse with a 24-bit target. In mode 2 it first issues a table-read request at the address made from the vector base and a device byte. It then waits for the 24-bit handler pointer and dispatches to that pointer. A halted core can be woken by an accepted interrupt or by key events. A dedicated wake key works even when interrupts are disabled. Pushing the program counter and executing the handler are left to the core.

Top module: `int_halt_ctrl`

## Requirements
- R1: After reset both enables are 0, the mode is 0, the vector base is 0, halted_o, busy_o, dispatch_o and tbl_req_o are 0.
- R2: A maskable request is taken only in an acceptance window. A window is a cycle with boundary_i or halted_o, and busy_o low. The master enable, after the strobes of that cycle are applied, must also be 1. Taking it clears both enables.
- R3: ei_i sets both enables, and no maskable request is taken in the cycle that carries ei_i. The earliest point of acceptance is therefore the end of the next instruction.
- R4: di_i clears both enables. retn_i copies the shadow enable into the master enable. The master enable rises only through ei_i or retn_i.
- R5: nmi_i is edge triggered. A rising edge outside a window stays pending until the next window. A level held high does not trigger again.
- R6: Taking an NMI copies the master enable into the shadow, clears the master enable and dispatches to 0x000066.
- R7: When an NMI and a maskable request are both present in one window, the NMI is taken.
- R8: In mode 1 a taken request dispatches to 0x000038. In mode 0 it dispatches to the device byte ANDed with 0x38, zero extended.
- R9: In mode 2 a taken request raises tbl_req_o with tbl_addr_o = {vector base, device byte} and sets busy_o. While busy, nothing is taken. When ptr_valid_i arrives, dispatch goes to ptr_data_i and busy_o clears.
- R10: im_set_i with im_sel_i of 0, 1 or 2 sets im_o to that value. The value 3 leaves the mode unchanged.
- R11: i_we_i loads i_data_i into the vector base used by mode 2.
- R12: halt_i at a boundary sets halted_o unless an interrupt is taken in that cycle. While halted, no boundary is needed for acceptance. A maskable request with the master enable at 0 does not wake the core.
- R13: wake_key_i clears halted_o without a dispatch. any_key_i clears it only while any_key_mode_i is 1.
- R14: dispatch_o and tbl_req_o are registered one-cycle pulses in the cycle after acceptance. dispatch_addr_o is 0 when dispatch_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary |
| irq_i | input | 1 | Maskable request, level |
| nmi_i | input | 1 | Non-maskable request, edge |
| wake_key_i | input | 1 | Wake key, ignores enables |
| any_key_i | input | 1 | Any key pressed |
| any_key_mode_i | input | 1 | Keypad in any-key wake mode |
| ei_i | input | 1 | Enable strobe |
| di_i | input | 1 | Disable strobe |
| retn_i | input | 1 | Return-from-NMI strobe |
| halt_i | input | 1 | Halt entry strobe |
| im_set_i | input | 1 | Mode select strobe |
| im_sel_i | input | 2 | Requested mode |
| i_we_i | input | 1 | Vector base load |
| i_data_i | input | 16 | Vector base value |
| vec_i | input | 8 | Device vector byte |
| ptr_valid_i | input | 1 | Handler pointer returned |
| ptr_data_i | input | 24 | Handler pointer |
| dispatch_o | output | 1 | Dispatch pulse |
| dispatch_addr_o | output | 24 | Dispatch target |
| tbl_req_o | output | 1 | Table read request pulse |
| tbl_addr_o | output | 24 | Table address |
| busy_o | output | 1 | Waiting for handler pointer |
| iff1_o | output | 1 | Master enable |
| iff2_o | output | 1 | Shadow enable |
| im_o | output | 2 | Current mode |
| halted_o | output | 1 | Halted state |

## Verification
Some properties are checked on every cycle:
- the master enable rises only after an enable or return strobe;
- halted_o falls only on a wake key or a dispatch;
- halted_o rises only after halt entry;
- an NMI dispatch always leaves the master enable clear;
- a table request comes with busy set;
- nothing dispatches while the pointer is still awaited.

Other behaviours need the bench's ordered scenarios:
- the one-instruction delay after enable;
- the pending and non-retriggering NMI edge;
- NMI priority;
- the per-mode targets;
- the mode 2 table address;
- the any-key gating.

// File: rtl/ihc_pkg.sv
package ihc_pkg;
  typedef enum logic [1:0] {
    IM_0 = 2'd0,
    IM_1 = 2'd1,
    IM_2 = 2'd2
  } im_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } disp_st_e;
endpackage

// File: rtl/ihc_cfg.sv
module ihc_cfg
  import ihc_pkg::*;
#(
  parameter int I_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           im_set_i,
  input  logic [1:0]     im_sel_i,
  input  logic           i_we_i,
  input  logic [I_W-1:0] i_data_i,
  output im_mode_e       im_o,
  output logic [I_W-1:0] i_o
);
  im_mode_e       im_q;
  logic [I_W-1:0] i_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      im_q <= IM_0;
      i_q  <= '0;
    end else begin
      if (im_set_i && im_sel_i != 2'd3) im_q <= im_mode_e'(im_sel_i);
      if (i_we_i) i_q <= i_data_i;
    end
  end

  assign im_o = im_q;
  assign i_o  = i_q;
endmodule

// File: rtl/ihc_enable.sv
module ihc_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ei_i,
  input  logic di_i,
  input  logic retn_i,
  input  logic take_nmi_i,
  input  logic take_irq_i,
  output logic iff1_post_o,
  output logic iff1_o,
  output logic iff2_o
);
  logic iff1_q, iff2_q;
  logic iff2_post;

  // enables as they stand once the finishing instruction's strobes apply
  always_comb begin
    if (di_i) begin
      iff1_post_o = 1'b0;
      iff2_post   = 1'b0;
    end else if (ei_i) begin
      iff1_post_o = 1'b1;
      iff2_post   = 1'b1;
    end else if (retn_i) begin
      iff1_post_o = iff2_q;
      iff2_post   = iff2_q;
    end else begin
      iff1_post_o = iff1_q;
      iff2_post   = iff2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
    end else if (take_nmi_i) begin
      iff1_q <= 1'b0;
      iff2_q <= iff1_post_o;
    end else if (take_irq_i) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
    end else begin
      iff1_q <= iff1_post_o;
      iff2_q <= iff2_post;
    end
  end

  assign iff1_o = iff1_q;
  assign iff2_o = iff2_q;
endmodule

// File: rtl/ihc_arb.sv
module ihc_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic irq_i,
  input  logic boundary_i,
  input  logic halted_i,
  input  logic busy_i,
  input  logic iff1_post_i,
  input  logic ei_i,
  output logic take_nmi_o,
  output logic take_irq_o
);
  logic nmi_q, pend_q;
  logic nmi_edge, window;

  assign nmi_edge   = nmi_i & ~nmi_q;
  assign window     = (boundary_i | halted_i) & ~busy_i;
  assign take_nmi_o = window & (pend_q | nmi_edge);
  assign take_irq_o = window & ~take_nmi_o & irq_i & iff1_post_i & ~ei_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_q <= take_nmi_o ? 1'b0 : (pend_q | nmi_edge);
    end
  end
endmodule

// File: rtl/ihc_halt.sv
module ihc_halt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  logic boundary_i,
  input  logic take_i,
  input  logic wake_key_i,
  input  logic any_key_i,
  input  logic any_key_mode_i,
  output logic halted_o
);
  logic halted_q;
  logic key_wake;

  assign key_wake = wake_key_i | (any_key_i & any_key_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     halted_q <= 1'b0;
    else if (take_i)                 halted_q <= 1'b0;
    else if (halted_q && key_wake)   halted_q <= 1'b0;
    else if (halt_i && boundary_i)   halted_q <= 1'b1;
  end

  assign halted_o = halted_q;
endmodule

// File: rtl/ihc_dispatch.sv
module ihc_dispatch
  import ihc_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                I_W      = 16,
  parameter int                VEC_W    = 8,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 24'h000066,
  parameter logic [ADDR_W-1:0] RST_ADDR = 24'h000038
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_nmi_i,
  input  logic              take_irq_i,
  input  im_mode_e          im_i,
  input  logic [I_W-1:0]    i_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              ptr_valid_i,
  input  logic [ADDR_W-1:0] ptr_data_i,
  output logic              dispatch_o,
  output logic [ADDR_W-1:0] dispatch_addr_o,
  output logic              tbl_req_o,
  output logic [ADDR_W-1:0] tbl_addr_o,
  output logic              busy_o
);
  localparam int TBL_W = I_W + VEC_W;
  localparam logic [VEC_W-1:0] RST_MASK = VEC_W'(8'h38);

  disp_st_e          st_q, st_d;
  logic              disp_d, tbl_d;
  logic [ADDR_W-1:0] disp_addr_d, tbl_addr_d;
  logic [ADDR_W-1:0] tbl_form, im0_form;

  always_comb begin
    tbl_form = '0;
    tbl_form[TBL_W-1:0] = {i_i, vec_i};
    im0_form = '0;
    im0_form[VEC_W-1:0] = vec_i & RST_MASK;
  end

  always_comb begin
    st_d        = st_q;
    disp_d      = 1'b0;
    disp_addr_d = '0;
    tbl_d       = 1'b0;
    tbl_addr_d  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (take_nmi_i) begin
          disp_d      = 1'b1;
          disp_addr_d = NMI_ADDR;
        end else if (take_irq_i) begin
          unique case (im_i)
            IM_2: begin
              tbl_d      = 1'b1;
              tbl_addr_d = tbl_form;
              st_d       = ST_WAIT;
            end
            IM_1: begin
              disp_d      = 1'b1;
              disp_addr_d = RST_ADDR;
            end
            default: begin
              disp_d      = 1'b1;
              disp_addr_d = im0_form;
            end
          endcase
        end
      end
      ST_WAIT: begin
        if (ptr_valid_i) begin
          disp_d      = 1'b1;
          disp_addr_d = ptr_data_i;
          st_d        = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q            <= ST_IDLE;
      dispatch_o      <= 1'b0;
      dispatch_addr_o <= '0;
      tbl_req_o       <= 1'b0;
      tbl_addr_o      <= '0;
    end else begin
      st_q            <= st_d;
      dispatch_o      <= disp_d;
      dispatch_addr_o <= disp_addr_d;
      tbl_req_o       <= tbl_d;
      tbl_addr_o      <= tbl_addr_d;
    end
  end

  assign busy_o = (st_q == ST_WAIT);
endmodule

// File: rtl/int_halt_ctrl.sv
module int_halt_ctrl
  import ihc_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                I_W      = 16,
  parameter int                VEC_W    = 8,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 24'h000066,
  parameter logic [ADDR_W-1:0] RST_ADDR = 24'h000038
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic              irq_i,
  input  logic              nmi_i,
  input  logic              wake_key_i,
  input  logic              any_key_i,
  input  logic              any_key_mode_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              retn_i,
  input  logic              halt_i,
  input  logic              im_set_i,
  input  logic [1:0]        im_sel_i,
  input  logic              i_we_i,
  input  logic [I_W-1:0]    i_data_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              ptr_valid_i,
  input  logic [ADDR_W-1:0] ptr_data_i,
  output logic              dispatch_o,
  output logic [ADDR_W-1:0] dispatch_addr_o,
  output logic              tbl_req_o,
  output logic [ADDR_W-1:0] tbl_addr_o,
  output logic              busy_o,
  output logic              iff1_o,
  output logic              iff2_o,
  output logic [1:0]        im_o,
  output logic              halted_o
);
  im_mode_e       im_w;
  logic [I_W-1:0] i_w;
  logic           iff1_post, take_nmi, take_irq;

  ihc_cfg #(.I_W(I_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .im_set_i (im_set_i),
    .im_sel_i (im_sel_i),
    .i_we_i   (i_we_i),
    .i_data_i (i_data_i),
    .im_o     (im_w),
    .i_o      (i_w)
  );

  ihc_enable u_enable (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ei_i        (ei_i),
    .di_i        (di_i),
    .retn_i      (retn_i),
    .take_nmi_i  (take_nmi),
    .take_irq_i  (take_irq),
    .iff1_post_o (iff1_post),
    .iff1_o      (iff1_o),
    .iff2_o      (iff2_o)
  );

  ihc_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nmi_i       (nmi_i),
    .irq_i       (irq_i),
    .boundary_i  (boundary_i),
    .halted_i    (halted_o),
    .busy_i      (busy_o),
    .iff1_post_i (iff1_post),
    .ei_i        (ei_i),
    .take_nmi_o  (take_nmi),
    .take_irq_o  (take_irq)
  );

  ihc_halt u_halt (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .halt_i         (halt_i),
    .boundary_i     (boundary_i),
    .take_i         (take_nmi | take_irq),
    .wake_key_i     (wake_key_i),
    .any_key_i      (any_key_i),
    .any_key_mode_i (any_key_mode_i),
    .halted_o       (halted_o)
  );

  ihc_dispatch #(
    .ADDR_W   (ADDR_W),
    .I_W      (I_W),
    .VEC_W    (VEC_W),
    .NMI_ADDR (NMI_ADDR),
    .RST_ADDR (RST_ADDR)
  ) u_dispatch (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .take_nmi_i      (take_nmi),
    .take_irq_i      (take_irq),
    .im_i            (im_w),
    .i_i             (i_w),
    .vec_i           (vec_i),
    .ptr_valid_i     (ptr_valid_i),
    .ptr_data_i      (ptr_data_i),
    .dispatch_o      (dispatch_o),
    .dispatch_addr_o (dispatch_addr_o),
    .tbl_req_o       (tbl_req_o),
    .tbl_addr_o      (tbl_addr_o),
    .busy_o          (busy_o)
  );

  assign im_o = im_w;
endmodule

// File: rtl/int_halt_ctrl_chk.sv
module int_halt_ctrl_chk #(
  parameter int                ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 24'h000066
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ei_i,
  input logic              retn_i,
  input logic              halt_i,
  input logic              wake_key_i,
  input logic              any_key_i,
  input logic              any_key_mode_i,
  input logic              ptr_valid_i,
  input logic              dispatch_o,
  input logic [ADDR_W-1:0] dispatch_addr_o,
  input logic              tbl_req_o,
  input logic              busy_o,
  input logic              iff1_o,
  input logic              halted_o
);
  AST_IFF1_RISE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iff1_o) |-> $past(ei_i || retn_i)); // R4

  AST_NMI_CLEARS_IFF1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispatch_o && dispatch_addr_o == NMI_ADDR && !$past(busy_o)) |-> !iff1_o); // R6

  AST_TBL_WITH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_req_o |-> busy_o); // R9

  AST_NO_DISP_WAITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ptr_valid_i) |=> !dispatch_o); // R9

  AST_HALT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> $past(halt_i)); // R12

  AST_HALT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halted_o) |-> ($past(wake_key_i) || $past(any_key_i && any_key_mode_i)
                         || dispatch_o || tbl_req_o)); // R13
endmodule

bind int_halt_ctrl int_halt_ctrl_chk #(.ADDR_W(ADDR_W), .NMI_ADDR(NMI_ADDR)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ei_i            (ei_i),
  .retn_i          (retn_i),
  .halt_i          (halt_i),
  .wake_key_i      (wake_key_i),
  .any_key_i       (any_key_i),
  .any_key_mode_i  (any_key_mode_i),
  .ptr_valid_i     (ptr_valid_i),
  .dispatch_o      (dispatch_o),
  .dispatch_addr_o (dispatch_addr_o),
  .tbl_req_o       (tbl_req_o),
  .busy_o          (busy_o),
  .iff1_o          (iff1_o),
  .halted_o        (halted_o)
);

// File: tb/int_halt_ctrl_tb_top.sv
`timescale 1ns/1ps
module int_halt_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        boundary_i = 0, irq_i = 0, nmi_i = 0, wake_key_i = 0;
  logic        any_key_i = 0, any_key_mode_i = 0, ei_i = 0, di_i = 0, retn_i = 0;
  logic        halt_i = 0, im_set_i = 0, i_we_i = 0, ptr_valid_i = 0;
  logic [1:0]  im_sel_i = '0;
  logic [15:0] i_data_i = '0;
  logic [7:0]  vec_i = 8'hD7;
  logic [23:0] ptr_data_i = '0;
  logic        dispatch_o, tbl_req_o, busy_o, iff1_o, iff2_o, halted_o;
  logic [23:0] dispatch_addr_o, tbl_addr_o;
  logic [1:0]  im_o;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  int_halt_ctrl dut_i (.*);

  typedef struct packed {
    logic bnd, irq, nmi, ei, di, retn, hlt, key, any, akm, ims;
    logic [1:0]  sel;
    logic        e_d;
    logic [23:0] e_a;
    logic        e_i1, e_i2, e_h;
  } vec_t;

  localparam int NV = 22;
  // bnd irq nmi ei di retn hlt key any akm ims sel | disp addr iff1 iff2 halted
  localparam vec_t VTAB [NV] = '{
    '{1,0,0,0,0,0,0,0,0,0,1,2'd1, 0,24'h0,      0,0,0}, // R10 mode 1
    '{1,1,0,0,0,0,0,0,0,0,0,2'd0, 0,24'h0,      0,0,0}, // R2 masked
    '{1,1,0,1,0,0,0,0,0,0,0,2'd0, 0,24'h0,      1,1,0}, // R3 blocked at EI
    '{1,1,0,0,0,0,0,0,0,0,0,2'd0, 1,24'h000038, 0,0,0}, // R8 R2
    '{1,0,0,1,0,0,0,0,0,0,0,2'd0, 0,24'h0,      1,1,0}, // R3
    '{0,0,1,0,0,0,0,0,0,0,0,2'd0, 0,24'h0,      1,1,0}, // R5 pending
    '{1,0,1,0,0,0,0,0,0,0,0,2'd0, 1,24'h000066, 0,1,0}, // R5 R6
    '{1,0,0,0,0,1,0,0,0,0,0,2'd0, 0,24'h0,      1,1,0}, // R4 retn
    '{1,1,1,0,0,0,0,0,0,0,0,2'd0, 1,24'h000066, 0,1,0}, // R7
    '{1,1,0,0,0,0,0,0,0,0,0,2'd0, 0,24'h0,      0,1,0}, // R2
    '{1,0,0,0,1,0,0,0,0,0,0,2'd0, 0,24'h0,      0,0,0}, // R4 di
    '{1,0,0,0,0,0,1,0,0,0,0,2'd0, 0,24'h0,      0,0,1}, // R12
    '{0,1,0,0,0,0,0,0,0,0,0,2'd0, 0,24'h0,      0,0,1}, // R12 no wake
    '{0,0,0,0,0,0,0,0,1,0,0,2'd0, 0,24'h0,      0,0,1}, // R13 gated
    '{0,0,0,0,0,0,0,0,1,1,0,2'd0, 0,24'h0,      0,0,0}, // R13 any key
    '{1,0,0,0,0,0,1,0,0,0,0,2'd0, 0,24'h0,      0,0,1}, // R12
    '{0,0,0,0,0,0,0,1,0,0,0,2'd0, 0,24'h0,      0,0,0}, // R13 wake key
    '{1,0,0,1,0,0,0,0,0,0,0,2'd0, 0,24'h0,      1,1,0}, // R3
    '{1,0,0,0,0,0,1,0,0,0,0,2'd0, 0,24'h0,      1,1,1}, // R12
    '{0,1,0,0,0,0,0,0,0,0,0,2'd0, 1,24'h000038, 0,0,0}, // R12 accept halted
    '{1,0,0,0,0,0,1,0,0,0,0,2'd0, 0,24'h0,      0,0,1}, // R12
    '{0,0,1,0,0,0,0,0,0,0,0,2'd0, 1,24'h000066, 0,0,0}  // R6 nmi in halt
  };

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic clr();
    boundary_i = 0; irq_i = 0; ei_i = 0; di_i = 0; retn_i = 0; halt_i = 0;
    wake_key_i = 0; any_key_i = 0; any_key_mode_i = 0; im_set_i = 0;
    i_we_i = 0; ptr_valid_i = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk("R1", {26'd0, iff1_o, iff2_o, halted_o, busy_o, dispatch_o, tbl_req_o}, 32'd0);
    chk("R1 mode", {30'd0, im_o}, 32'd0);
    rst_ni = 1'b1;
    tick();

    for (int k = 0; k < NV; k++) begin
      boundary_i = VTAB[k].bnd; irq_i = VTAB[k].irq; nmi_i = VTAB[k].nmi;
      ei_i = VTAB[k].ei; di_i = VTAB[k].di; retn_i = VTAB[k].retn;
      halt_i = VTAB[k].hlt; wake_key_i = VTAB[k].key; any_key_i = VTAB[k].any;
      any_key_mode_i = VTAB[k].akm; im_set_i = VTAB[k].ims; im_sel_i = VTAB[k].sel;
      tick();
      chk($sformatf("table row %0d", k),
          {dispatch_o, dispatch_addr_o, iff1_o, iff2_o, halted_o},
          {VTAB[k].e_d, VTAB[k].e_a, VTAB[k].e_i1, VTAB[k].e_i2, VTAB[k].e_h});
      clr();
      nmi_i = 0;
    end
    tick();

    // R10 value 3 ignored, R8 mode 0 target
    boundary_i = 1; im_set_i = 1; im_sel_i = 2'd0; tick(); clr();
    boundary_i = 1; im_set_i = 1; im_sel_i = 2'd3; tick(); clr();
    chk("R10 sel3", {30'd0, im_o}, 32'd0);
    boundary_i = 1; ei_i = 1; tick(); clr();
    vec_i = 8'hD7; boundary_i = 1; irq_i = 1; tick(); clr();
    chk("R8 mode0", {7'd0, dispatch_o, dispatch_addr_o}, {7'd0, 1'b1, 24'h000010});
    tick();
    chk("R14 pulse", {31'd0, dispatch_o}, 32'd0);

    // R11 R9 mode 2 table flow
    boundary_i = 1; im_set_i = 1; im_sel_i = 2'd2; i_we_i = 1; i_data_i = 16'hA5C3; tick(); clr();
    chk("R10 sel2", {30'd0, im_o}, 32'd2);
    boundary_i = 1; ei_i = 1; tick(); clr();
    vec_i = 8'h7E; boundary_i = 1; irq_i = 1; tick(); clr();
    chk("R9 R11 table", {6'd0, tbl_req_o, busy_o, tbl_addr_o}, {6'd0, 1'b1, 1'b1, 24'hA5C37E});
    chk("R9 no early dispatch", {31'd0, dispatch_o}, 32'd0);
    boundary_i = 1; nmi_i = 1; tick(); clr();
    chk("R9 blocked while busy", {30'd0, dispatch_o, busy_o}, 32'd1);
    ptr_valid_i = 1; ptr_data_i = 24'h123456; tick(); clr();
    chk("R9 pointer dispatch", {6'd0, dispatch_o, busy_o, dispatch_addr_o}, {6'd0, 1'b1, 1'b0, 24'h123456});
    boundary_i = 1; tick(); clr();
    chk("R5 pending after busy", {7'd0, dispatch_o, dispatch_addr_o}, {7'd0, 1'b1, 24'h000066});
    boundary_i = 1; tick(); clr();
    chk("R5 level no retrigger", {31'd0, dispatch_o}, 32'd0);
    nmi_i = 0;

    // R12 halt entry overridden by acceptance
    boundary_i = 1; im_set_i = 1; im_sel_i = 2'd1; tick(); clr();
    boundary_i = 1; ei_i = 1; tick(); clr();
    boundary_i = 1; halt_i = 1; irq_i = 1; tick(); clr();
    chk("R12 halt vs accept", {6'd0, halted_o, dispatch_o, dispatch_addr_o}, {6'd0, 1'b0, 1'b1, 24'h000038});

    tick();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule